// File: doc/BRIEF.md
# Timer unit register front end

This block sits between a simple single-cycle register bus and the channels of a small timer unit. It decodes a 48-byte register window. The window holds an optional output-control register, a start register whose low bits switch each channel on or off, and one register group per channel. The channel groups start at the irregular bases 0x08, 0x14 and 0x20.

An access that lands in a channel group is passed on to that channel's local register port in the same cycle. The passed-on offset is the bus address minus the group base, so each channel sees offsets starting at zero. Read data comes back one cycle after the access, whether it comes from the front end's own registers or from a channel.

The unit comes in a two-channel or three-channel build. The output-control register can also be left out. Bad accesses never stall or fault the bus. They return zero on reads and raise a one-cycle error pulse in the cycle after the access.

Top module: `tmr_regdec`

## Requirements
- R1: After reset, ch_enable, out_ctl, bus_rdata and bus_err are all 0.
- R2: A write to offset 0x04 loads ch_enable from wdata bits [NCH-1:0] in the next cycle, and ch_enable holds otherwise. A read of 0x04 returns ch_enable in bits [NCH-1:0], with every higher bit 0.
- R3: With HAS_OUTCTL=1, a write to offset 0x00 loads out_ctl from wdata[OUTCTL_W-1:0], and a read of 0x00 returns that value zero-extended. With HAS_OUTCTL=0, an access to 0x00 is a bad access and reads return 0.
- R4: An access in 0x08..0x13, 0x14..0x1F or 0x20..0x2F drives ch_sel to a one-hot value in the same cycle: bit 0, bit 1 or bit 2. In that cycle ch_addr is the address minus 0x08, 0x14 or 0x20, and ch_write and ch_wdata equal the bus values. ch_sel is 0 when no channel access is made.
- R5: A read of a channel group returns, one cycle later on bus_rdata, the value the selected channel drove on its slice of ch_rdata during the access cycle.
- R6: With HAS_CH2=0, an access at 0x20..0x2F selects no channel and is a bad access. A write to 0x04 with wdata bit 2 set is also a bad access, but bits 0 and 1 still load.
- R7: Offsets 0x01..0x03, 0x05..0x07 and 0x30 and above are unmapped. Reads of them return 0, writes to them change neither ch_enable nor out_ctl, and both raise bus_err.
- R8: bus_err is high for exactly the one cycle after a bad access, and low after any other cycle. bus_rdata is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the read |
| bus_err | output | 1 | One-cycle pulse after a bad access |
| ch_sel | output | NCH | One-hot channel select |
| ch_write | output | 1 | Write strobe to the channels |
| ch_addr | output | LOC_W | Offset local to the selected group |
| ch_wdata | output | DATA_W | Write data to the channels |
| ch_rdata | input | NCH*DATA_W | Channel read data, channel i at slice i |
| ch_enable | output | NCH | Per-channel run enable |
| out_ctl | output | OUTCTL_W | Output-control register |

## Verification
A decode table that is off by one byte at a group boundary shows up in the same cycle, as the wrong ch_sel bit or a shifted ch_addr. It also shows up one cycle later, as a stub value carrying the wrong channel tag or offset. A start register that loads too many bits, or loads on the wrong offset, is visible on ch_enable in the cycle after the write. A bad-access flag that is missed or stuck high appears on bus_err exactly one cycle after the access. Every one of the 64 offsets is therefore swept for reads and writes in both the full build and the minimal build.

// File: rtl/tmr_regdec_pkg.sv
package tmr_regdec_pkg;

   typedef enum logic [2:0] {
      RG_OCTL  = 3'd0,
      RG_START = 3'd1,
      RG_CH0   = 3'd2,
      RG_CH1   = 3'd3,
      RG_CH2   = 3'd4,
      RG_BAD   = 3'd5
   } region_t;

   localparam int OFS_OCTL  = 'h00;
   localparam int OFS_START = 'h04;
   localparam int BASE_CH0  = 'h08;
   localparam int BASE_CH1  = 'h14;
   localparam int BASE_CH2  = 'h20;
   localparam int WIN_END   = 'h30;

endpackage

// File: rtl/tmr_regdec_map.sv
module tmr_regdec_map
   import tmr_regdec_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LOC_W      = 4,
   parameter bit HAS_CH2    = 1'b1,
   parameter bit HAS_OUTCTL = 1'b1
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wbit2,
   output region_t           region,
   output logic [LOC_W-1:0]  loc,
   output logic              bad
);

   logic [ADDR_W-1:0] diff;

   always_comb begin
      region = RG_BAD;
      diff   = '0;
      if (addr == ADDR_W'(OFS_OCTL)) begin
         region = HAS_OUTCTL ? RG_OCTL : RG_BAD;
      end else if (addr == ADDR_W'(OFS_START)) begin
         region = RG_START;
      end else if (addr >= ADDR_W'(BASE_CH0) && addr < ADDR_W'(BASE_CH1)) begin
         region = RG_CH0;
         diff   = addr - ADDR_W'(BASE_CH0);
      end else if (addr >= ADDR_W'(BASE_CH1) && addr < ADDR_W'(BASE_CH2)) begin
         region = RG_CH1;
         diff   = addr - ADDR_W'(BASE_CH1);
      end else if (addr >= ADDR_W'(BASE_CH2) && addr < ADDR_W'(WIN_END)) begin
         region = HAS_CH2 ? RG_CH2 : RG_BAD;
         diff   = addr - ADDR_W'(BASE_CH2);
      end
   end

   assign loc = diff[LOC_W-1:0];

   assign bad = valid && ((region == RG_BAD) ||
                          (!HAS_CH2 && region == RG_START && write && wbit2));

endmodule

// File: rtl/tmr_regdec_ctl.sv
module tmr_regdec_ctl #(
   parameter int DATA_W     = 32,
   parameter int NCH        = 3,
   parameter int OUTCTL_W   = 8,
   parameter bit HAS_OUTCTL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_start,
   input  logic                we_octl,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NCH-1:0]      start_q,
   output logic [OUTCTL_W-1:0] octl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        start_q <= '0;
      else if (we_start) start_q <= wdata[NCH-1:0];
   end

   generate
      if (HAS_OUTCTL) begin : g_octl
         logic [OUTCTL_W-1:0] octl_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       octl_r <= '0;
            else if (we_octl) octl_r <= wdata[OUTCTL_W-1:0];
         end
         assign octl_q = octl_r;
      end else begin : g_no_octl
         logic unused_we;
         assign unused_we = we_octl;
         assign octl_q    = '0;
      end
   endgenerate

endmodule

// File: rtl/tmr_regdec_rd.sv
module tmr_regdec_rd
   import tmr_regdec_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NCH      = 3,
   parameter int OUTCTL_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_en,
   input  logic                  bad,
   input  region_t               region,
   input  logic [NCH-1:0]        start_q,
   input  logic [OUTCTL_W-1:0]   octl_q,
   input  logic [NCH*DATA_W-1:0] ch_rdata,
   output logic [DATA_W-1:0]     rdata,
   output logic                  err
);

   logic [DATA_W-1:0] mux;

   always_comb begin
      mux = '0;
      case (region)
         RG_OCTL:  mux = DATA_W'(octl_q);
         RG_START: mux = DATA_W'(start_q);
         RG_CH0:   mux = ch_rdata[0 +: DATA_W];
         RG_CH1:   mux = ch_rdata[DATA_W +: DATA_W];
         RG_CH2:   if (NCH > 2) mux = ch_rdata[(NCH-1)*DATA_W +: DATA_W];
         default:  mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         rdata <= rd_en ? mux : '0;
         err   <= bad;
      end
   end

endmodule

// File: rtl/tmr_regdec.sv
module tmr_regdec
   import tmr_regdec_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 32,
   parameter int LOC_W      = 4,
   parameter int OUTCTL_W   = 8,
   parameter bit HAS_CH2    = 1'b1,
   parameter bit HAS_OUTCTL = 1'b1,
   localparam int NCH       = HAS_CH2 ? 3 : 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic                  bus_write,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  bus_err,
   output logic [NCH-1:0]        ch_sel,
   output logic                  ch_write,
   output logic [LOC_W-1:0]      ch_addr,
   output logic [DATA_W-1:0]     ch_wdata,
   input  logic [NCH*DATA_W-1:0] ch_rdata,
   output logic [NCH-1:0]        ch_enable,
   output logic [OUTCTL_W-1:0]   out_ctl
);

   generate
      if (ADDR_W < 6)          begin : g_bad_aw  $error("ADDR_W must cover the 0x30 window"); end
      if (LOC_W < 4)           begin : g_bad_lw  $error("LOC_W must cover a 16-byte group"); end
      if (DATA_W < OUTCTL_W)   begin : g_bad_ow  $error("OUTCTL_W exceeds DATA_W"); end
      if (DATA_W < 3)          begin : g_bad_dw  $error("DATA_W too narrow for start bits"); end
   endgenerate

   region_t region;
   logic    bad;
   logic    wr_ok;

   tmr_regdec_map #(
      .ADDR_W(ADDR_W), .LOC_W(LOC_W), .HAS_CH2(HAS_CH2), .HAS_OUTCTL(HAS_OUTCTL)
   ) u_map (
      .valid(bus_valid), .write(bus_write), .addr(bus_addr), .wbit2(bus_wdata[2]),
      .region(region), .loc(ch_addr), .bad(bad)
   );

   assign wr_ok = bus_valid && bus_write;

   tmr_regdec_ctl #(
      .DATA_W(DATA_W), .NCH(NCH), .OUTCTL_W(OUTCTL_W), .HAS_OUTCTL(HAS_OUTCTL)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .we_start(wr_ok && region == RG_START),
      .we_octl(wr_ok && region == RG_OCTL),
      .wdata(bus_wdata), .start_q(ch_enable), .octl_q(out_ctl)
   );

   tmr_regdec_rd #(
      .DATA_W(DATA_W), .NCH(NCH), .OUTCTL_W(OUTCTL_W)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(bus_valid && !bus_write), .bad(bad),
      .region(region), .start_q(ch_enable), .octl_q(out_ctl),
      .ch_rdata(ch_rdata), .rdata(bus_rdata), .err(bus_err)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_sel
         assign ch_sel[gi] = bus_valid && (region == region_t'(int'(RG_CH0) + gi));
      end
   endgenerate

   assign ch_write = bus_write;
   assign ch_wdata = bus_wdata;

endmodule

// File: rtl/tmr_regdec_chk.sv
module tmr_regdec_chk #(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 32,
   parameter int LOC_W      = 4,
   parameter int NCH        = 3,
   parameter bit HAS_CH2    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_err,
   input logic [NCH-1:0]    ch_sel,
   input logic [LOC_W-1:0]  ch_addr,
   input logic [NCH-1:0]    ch_enable
);

   logic unmapped;
   assign unmapped = (bus_addr >= ADDR_W'('h30)) ||
                     (bus_addr >= ADDR_W'(1) && bus_addr <= ADDR_W'(3)) ||
                     (bus_addr >= ADDR_W'(5) && bus_addr <= ADDR_W'(7));

   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_write && bus_addr == ADDR_W'(4) |=> ch_enable == $past(bus_wdata[NCH-1:0]));

   assert_start_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write && bus_addr == ADDR_W'(4)) |=> $stable(ch_enable));

   assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_sel) && (!bus_valid -> ch_sel == '0));

   assert_ch0_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_sel[0] |-> ch_addr == LOC_W'(bus_addr - ADDR_W'(8)));

   assert_unmapped_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && unmapped |=> bus_err);

   assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_write && unmapped |=> bus_rdata == '0);

   assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !bus_err);

   assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> bus_rdata == '0);

   generate
      if (!HAS_CH2) begin : g_two
         assert_no_ch2_R6: assert property (@(posedge clk) disable iff (!rst_n)
            bus_valid && bus_addr >= ADDR_W'('h20) |=> bus_err);
      end
   endgenerate

endmodule

bind tmr_regdec tmr_regdec_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOC_W(LOC_W), .NCH(NCH), .HAS_CH2(HAS_CH2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .bus_err(bus_err), .ch_sel(ch_sel), .ch_addr(ch_addr), .ch_enable(ch_enable)
);

// File: tb/tmr_regdec_tb.sv
module tmr_regdec_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [5:0]  bus_addr  = '0;
   logic [31:0] bus_wdata = '0;

   logic [31:0] rd_a, rd_b;
   logic        err_a, err_b;
   logic [2:0]  sel_a, en_a;
   logic [1:0]  sel_b, en_b;
   logic        wr_a, wr_b;
   logic [3:0]  loc_a, loc_b;
   logic [31:0] wd_a, wd_b;
   logic [7:0]  oc_a, oc_b;
   logic [95:0] crd_a;
   logic [63:0] crd_b;

   function automatic logic [31:0] stub(int ch, logic [3:0] loc);
      return 32'h5A00_0000 | (32'(ch) << 12) | 32'(loc);
   endfunction

   always_comb for (int i = 0; i < 3; i++) crd_a[i*32 +: 32] = stub(i, loc_a);
   always_comb for (int i = 0; i < 2; i++) crd_b[i*32 +: 32] = stub(i, loc_b);

   tmr_regdec #(.HAS_CH2(1'b1), .HAS_OUTCTL(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a), .bus_err(err_a),
      .ch_sel(sel_a), .ch_write(wr_a), .ch_addr(loc_a), .ch_wdata(wd_a),
      .ch_rdata(crd_a), .ch_enable(en_a), .out_ctl(oc_a));

   tmr_regdec #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) u_dut_min (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b), .bus_err(err_b),
      .ch_sel(sel_b), .ch_write(wr_b), .ch_addr(loc_b), .ch_wdata(wd_b),
      .ch_rdata(crd_b), .ch_enable(en_b), .out_ctl(oc_b));

   int total = 0;
   int bad   = 0;
   logic [2:0] m_en_a;
   logic [1:0] m_en_b;
   logic [7:0] m_oc_a;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Region code: 0 octl, 1 start, 2..4 channel, 5 unmapped
   function automatic int reg_of(int a, bit full);
      if (a == 0)  return full ? 0 : 5;
      if (a == 4)  return 1;
      if (a >= 8  && a < 20) return 2;
      if (a >= 20 && a < 32) return 3;
      if (a >= 32 && a < 48) return full ? 4 : 5;
      return 5;
   endfunction

   function automatic int base_of(int r);
      return (r == 2) ? 8 : (r == 3) ? 20 : 32;
   endfunction

   task automatic access(bit w, int a, logic [31:0] d);
      int ra, rb;
      logic [31:0] xa, xb;
      bit ea, eb;
      ra = reg_of(a, 1'b1);
      rb = reg_of(a, 1'b0);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = w; bus_addr = 6'(a); bus_wdata = d;
      #1;
      // R4: same-cycle forwarding
      chk("R4 sel full", 32'(sel_a), (ra >= 2 && ra <= 4) ? 32'(1 << (ra - 2)) : 0);
      chk("R6 sel min",  32'(sel_b), (rb >= 2 && rb <= 3) ? 32'(1 << (rb - 2)) : 0);
      if (ra >= 2 && ra <= 4) chk("R4 loc full", 32'(loc_a), 32'(a - base_of(ra)));
      if (rb >= 2 && rb <= 3) chk("R4 loc min",  32'(loc_b), 32'(a - base_of(rb)));
      chk("R4 write pass", {30'd0, wr_a, wr_b}, {30'd0, w, w});
      chk("R4 wdata pass", wd_a, d);
      // expected read values, based on state before this access
      xa = 0; xb = 0;
      case (ra)
         0: xa = 32'(m_oc_a);
         1: xa = 32'(m_en_a);
         2, 3, 4: xa = stub(ra - 2, 4'(a - base_of(ra)));
         default: xa = 0;
      endcase
      case (rb)
         1: xb = 32'(m_en_b);
         2, 3: xb = stub(rb - 2, 4'(a - base_of(rb)));
         default: xb = 0;
      endcase
      if (w) begin xa = 0; xb = 0; end
      ea = (ra == 5);
      eb = (rb == 5) || (w && rb == 1 && d[2]);
      // model update
      if (w && ra == 0) m_oc_a = d[7:0];
      if (w && ra == 1) m_en_a = d[2:0];
      if (w && rb == 1) m_en_b = d[1:0];
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      chk(rb == 4 ? "R6 rdata" : (ra == 5 ? "R7 rdata full" : "R5 rdata full"), rd_a, xa);
      chk(rb == 5 && a >= 32 && a < 48 ? "R6 rdata min" : "R5 rdata min", rd_b, xb);
      chk(ea ? "R7 err full" : "R8 err full", 32'(err_a), 32'(ea));
      chk(eb ? "R6 err min" : "R8 err min", 32'(err_b), 32'(eb));
      chk("R2 enable full", 32'(en_a), 32'(m_en_a));
      chk("R2 enable min",  32'(en_b), 32'(m_en_b));
      chk("R3 outctl full", 32'(oc_a), 32'(m_oc_a));
      chk("R3 outctl min",  32'(oc_b), 32'd0);
   endtask

   task automatic idle_check();
      @(negedge clk);
      chk("R8 idle err", {30'd0, err_a, err_b}, 0);
      chk("R8 idle rdata", rd_a | rd_b, 0);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_en_a = 0; m_en_b = 0; m_oc_a = 0;
      repeat (3) @(negedge clk);
      chk("R1 rdata", rd_a | rd_b, 0);
      chk("R1 err", {30'd0, err_a, err_b}, 0);
      chk("R1 enable", {27'd0, en_a, en_b}, 0);
      chk("R1 outctl", {16'd0, oc_a, oc_b}, 0);
      rst_n = 1'b1;
      // sweep reads over all offsets in reset state
      for (int a = 0; a < 64; a++) access(1'b0, a, 32'h0);
      idle_check();
      // start register patterns incl. bit 2 in the minimal build
      access(1'b1, 4, 32'hFFFF_FFFF);  // R2, R6
      access(1'b0, 4, 0);
      access(1'b1, 4, 32'h0000_0005);  // R6: bit 2 set in min build
      access(1'b0, 4, 0);
      access(1'b1, 4, 32'h0000_0002);
      access(1'b0, 4, 0);
      // output control
      access(1'b1, 0, 32'h1234_5678);  // R3
      access(1'b0, 0, 0);
      access(1'b1, 0, 32'hFFFF_FFA5);
      access(1'b0, 0, 0);
      idle_check();
      // write sweep: every offset with a distinct pattern (R7: unmapped writes are inert)
      for (int a = 0; a < 64; a++) begin
         if (a != 0 && a != 4) access(1'b1, a, 32'hC3C3_0000 | 32'(a) | 32'h7);
      end
      // reads after the write sweep show the registers untouched
      access(1'b0, 0, 0);
      access(1'b0, 4, 0);
      for (int a = 0; a < 64; a++) access(1'b0, a, 0);
      access(1'b1, 4, 0);
      access(1'b0, 4, 0);
      idle_check();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule